// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Read Timing

This block is one FIFO channel in which the write port and the read port share a single clock. Right after a master reset it captures a timing-style input once. A high level gives conventional timing. A low level gives fall-through timing. In conventional timing every word is fetched by a read request, and the two status outputs act as an active-low full flag and an active-low empty flag. In fall-through timing the oldest word is moved into an output stage without any request. The status outputs then act as input-ready and output-ready, and a read request consumes the word being shown.

The almost-empty and almost-full thresholds arrive on input buses. They are captured on the same clock edge as the timing style, so later changes on those buses have no effect. A master reset empties the channel and arms a new capture. A partial reset, sampled on the clock, empties the channel but keeps the captured style and thresholds. The depth is a power-of-two parameter and the word width is a parameter.

Top module: `twomode_fifo`

## Requirements
- R1: While `rst_n` is low, and until the first rising edge after its release, the outputs are: `rd_data` = 0, `room_flag` = 0, `data_flag` = 0, `ae_flag` = 1, `af_flag` = 0.
- R2: On the first rising edge after `rst_n` goes high, the block captures its configuration: `mode_sel` low selects fall-through timing and high selects conventional timing, and `ae_off` and `af_off` are captured on that same edge. Writes, reads and partial resets on that edge are ignored.
- R3: After the capture edge, changes on `mode_sel`, `ae_off` and `af_off` have no effect until the next master reset.
- R4: In conventional timing, a read on an edge where the FIFO holds data places the oldest word on `rd_data` after that edge. `rd_data` holds its value at all other times. `data_flag` is high exactly when at least one word is stored.
- R5: In fall-through timing, a word written into an empty FIFO appears on `rd_data` with `data_flag` high after the second rising edge, counting the write edge as the first. No read is needed.
- R6: In fall-through timing, the shown word is replaced only by a read on an edge where `data_flag` is high. The next stored word then appears after that edge, or `data_flag` falls if no word is stored.
- R7: Occupancy counts stored words plus, in fall-through timing, the word in the output stage. `room_flag` is low exactly when occupancy equals DEPTH, and a write at that point is ignored.
- R8: A read while the FIFO is empty (conventional) or while `data_flag` is low (fall-through) is ignored.
- R9: A write and a read accepted on the same edge both take effect, and word order is preserved.
- R10: `ae_flag` is high when occupancy is at or below the captured empty threshold. `af_flag` is high when DEPTH minus occupancy is at or below the captured full threshold.
- R11: `flush_n` low on a rising edge after capture empties the FIFO and clears `rd_data` to 0, while the captured timing style and thresholds are kept.
- R12: A master reset discards all stored words and arms a new capture of the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Master reset, asynchronous, active low |
| flush_n | input | 1 | Partial reset, synchronous, active low |
| mode_sel | input | 1 | Timing style, captured once: 0 fall-through, 1 conventional |
| ae_off | input | CNT_W | Almost-empty threshold, captured once |
| af_off | input | CNT_W | Almost-full threshold, captured once |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read word |
| room_flag | output | 1 | Not full (conventional) / input ready (fall-through) |
| data_flag | output | 1 | Not empty (conventional) / output ready (fall-through) |
| ae_flag | output | 1 | Almost empty |
| af_flag | output | 1 | Almost full |

## Verification
The bench fills the FIFO past full and drains it past empty. A design that let either request through would corrupt the word order or wrap a pointer. In fall-through timing it watches the two-edge arrival of a word written into an empty FIFO and the hold of the shown word when no read arrives; a design that skipped a stage or advanced on its own would show the wrong word. It changes the style and threshold inputs after capture, flushes with data in flight, and repeats master resets with data stored, so that a design that kept sampling, forgot its thresholds or kept stale words would disagree with the reference model.

// File: rtl/twomode_fifo_pkg.sv
package twomode_fifo_pkg;

  // Read timing style captured after master reset.
  typedef enum logic {
    TM_STD  = 1'b0,
    TM_FALL = 1'b1
  } tmode_e;

  // Translate the style pin level into the captured style.
  function automatic tmode_e decode_style(input logic pin);
    return pin ? TM_STD : TM_FALL;
  endfunction

endpackage

// File: rtl/twomode_fifo_cfg.sv
module twomode_fifo_cfg
  import twomode_fifo_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic [CNT_W-1:0] ae_in,
  input  logic [CNT_W-1:0] af_in,
  output logic             cfg_done,
  output tmode_e           mode_q,
  output logic [CNT_W-1:0] ae_q,
  output logic [CNT_W-1:0] af_q
);

  logic             cap;
  logic             done_d;
  tmode_e           mode_d;
  logic [CNT_W-1:0] ae_d;
  logic [CNT_W-1:0] af_d;

  // Capture exactly once per master reset.
  always_comb begin
    cap    = ~cfg_done;
    done_d = 1'b1;
    mode_d = decode_style(mode_sel);
    ae_d   = ae_in;
    af_d   = af_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done <= 1'b0;
      mode_q   <= TM_STD;
      ae_q     <= '0;
      af_q     <= '0;
    end else if (cap) begin
      cfg_done <= done_d;
      mode_q   <= mode_d;
      ae_q     <= ae_d;
      af_q     <= af_d;
    end
  end

endmodule

// File: rtl/twomode_fifo_ptr.sv
module twomode_fifo_ptr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] wr_ptr,
  output logic [CNT_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] ram_cnt
);

  logic [CNT_W-1:0] wr_d;
  logic [CNT_W-1:0] rd_d;
  logic             ptr_en;

  // Pointers carry one extra wrap bit so that full and empty differ.
  always_comb begin
    ptr_en = clr | push | pop;
    wr_d   = wr_ptr;
    rd_d   = rd_ptr;
    if (clr) begin
      wr_d = '0;
      rd_d = '0;
    end else begin
      if (push) wr_d = wr_ptr + CNT_W'(1);
      if (pop)  rd_d = rd_ptr + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (ptr_en) begin
      wr_ptr <= wr_d;
      rd_ptr <= rd_d;
    end
  end

  assign ram_cnt = wr_ptr - rd_ptr;

endmodule

// File: rtl/twomode_fifo_mem.sv
module twomode_fifo_mem #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  // Storage carries no reset; validity is tracked by the pointers.
  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/twomode_fifo_out.sv
module twomode_fifo_out
  import twomode_fifo_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  tmode_e            mode,
  input  logic              rd_en,
  input  logic              ram_has,
  input  logic [DATA_W-1:0] mem_q,
  output logic              pop,
  output logic              stage_v,
  output logic [DATA_W-1:0] rd_data
);

  logic              take;
  logic              load;
  logic              stage_d;
  logic [DATA_W-1:0] data_d;
  logic              out_en;

  always_comb begin
    take = rd_en & stage_v;
    if (mode == TM_FALL) begin
      load = ram_has & (~stage_v | take);
    end else begin
      load = rd_en & ram_has;
    end
    pop     = run & load;
    stage_d = stage_v;
    data_d  = rd_data;
    if (clr) begin
      stage_d = 1'b0;
      data_d  = '0;
    end else if (run) begin
      if (pop) data_d = mem_q;
      if (mode == TM_FALL) begin
        if (pop)       stage_d = 1'b1;
        else if (take) stage_d = 1'b0;
      end else begin
        stage_d = 1'b0;
      end
    end
    out_en = clr | run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_v <= 1'b0;
      rd_data <= '0;
    end else if (out_en) begin
      stage_v <= stage_d;
      rd_data <= data_d;
    end
  end

endmodule

// File: rtl/twomode_fifo.sv
module twomode_fifo
  import twomode_fifo_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 36,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_n,
  input  logic              mode_sel,
  input  logic [CNT_W-1:0]  ae_off,
  input  logic [CNT_W-1:0]  af_off,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              room_flag,
  output logic              data_flag,
  output logic              ae_flag,
  output logic              af_flag
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic              cfg_done;
  tmode_e            mode;
  logic [CNT_W-1:0]  ae_q;
  logic [CNT_W-1:0]  af_q;
  logic [CNT_W-1:0]  wr_ptr;
  logic [CNT_W-1:0]  rd_ptr;
  logic [CNT_W-1:0]  ram_cnt;
  logic [CNT_W-1:0]  occ;
  logic [CNT_W-1:0]  free_cnt;
  logic [DATA_W-1:0] mem_q;
  logic              run;
  logic              clr;
  logic              full;
  logic              push;
  logic              pop;
  logic              ram_has;
  logic              stage_v;
  logic              fall_mode;

  twomode_fifo_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .ae_in    (ae_off),
    .af_in    (af_off),
    .cfg_done (cfg_done),
    .mode_q   (mode),
    .ae_q     (ae_q),
    .af_q     (af_q)
  );

  // Accesses and flush are honoured only once the configuration is held.
  always_comb begin
    run       = cfg_done & flush_n;
    clr       = cfg_done & ~flush_n;
    fall_mode = (mode == TM_FALL);
    ram_has   = (ram_cnt != '0);
    occ       = ram_cnt + CNT_W'(fall_mode & stage_v);
    free_cnt  = DEPTH_C - occ;
    full      = (occ == DEPTH_C);
    push      = run & wr_en & ~full;
  end

  twomode_fifo_ptr #(.CNT_W(CNT_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .push    (push),
    .pop     (pop),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .ram_cnt (ram_cnt)
  );

  twomode_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (push),
    .waddr (wr_ptr[ADDR_W-1:0]),
    .wdata (wr_data),
    .raddr (rd_ptr[ADDR_W-1:0]),
    .rdata (mem_q)
  );

  twomode_fifo_out #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .clr     (clr),
    .mode    (mode),
    .rd_en   (rd_en),
    .ram_has (ram_has),
    .mem_q   (mem_q),
    .pop     (pop),
    .stage_v (stage_v),
    .rd_data (rd_data)
  );

  always_comb begin
    room_flag = cfg_done & ~full;
    data_flag = fall_mode ? stage_v : ram_has;
    ae_flag   = (occ <= ae_q);
    af_flag   = (free_cnt <= af_q);
  end

endmodule

// File: rtl/twomode_fifo_chk.sv
module twomode_fifo_chk #(
  parameter int DATA_W = 36,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_n,
  input logic              rd_en,
  input logic              cfg_done,
  input logic              fall_mode,
  input logic              room_flag,
  input logic              data_flag,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  wr_ptr,
  input logic [CNT_W-1:0]  rd_ptr
);

  p_capture_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |=> cfg_done);

  p_mode_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> (cfg_done && $stable(fall_mode)));

  p_std_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && !fall_mode && !rd_en && flush_n) |=> $stable(rd_data));

  p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_mode && data_flag && !rd_en && flush_n) |=> (data_flag && $stable(rd_data)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!room_flag && flush_n) |=> $stable(wr_ptr));

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_mode && !data_flag && flush_n) |=> $stable(rd_ptr));

  p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && !flush_n) |=> (!data_flag && room_flag && rd_data == '0));

endmodule

bind twomode_fifo twomode_fifo_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush_n   (flush_n),
  .rd_en     (rd_en),
  .cfg_done  (cfg_done),
  .fall_mode (fall_mode),
  .room_flag (room_flag),
  .data_flag (data_flag),
  .rd_data   (rd_data),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr)
);

// File: tb/twomode_fifo_test.sv
`timescale 1ns/1ps
module twomode_fifo_test;
  localparam int DEPTH = 16;
  localparam int DW    = 36;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n, flush_n, mode_sel, wr_en, rd_en;
  logic [CW-1:0] ae_off, af_off;
  logic [DW-1:0] wr_data, rd_data;
  logic          room_flag, data_flag, ae_flag, af_flag;

  always #2 clk = ~clk;

  twomode_fifo #(.DEPTH(DEPTH), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .flush_n(flush_n), .mode_sel(mode_sel),
    .ae_off(ae_off), .af_off(af_off), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .room_flag(room_flag),
    .data_flag(data_flag), .ae_flag(ae_flag), .af_flag(af_flag)
  );

  int total = 0;
  int bad   = 0;
  bit scram = 0;

  // Reference model state.
  logic [DW-1:0] mq[$];
  bit            m_cfg, m_fall, m_sv;
  logic [DW-1:0] m_rd;
  int            m_aeo, m_afo;
  string         m_tag;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_occ();
    return mq.size() + ((m_fall && m_sv) ? 1 : 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_cfg = 0; m_fall = 0; m_sv = 0; m_rd = '0;
      m_aeo = 0; m_afo = 0; m_tag = "R1";
    end else if (!m_cfg) begin
      m_cfg = 1; m_fall = !mode_sel; m_aeo = ae_off; m_afo = af_off; m_tag = "R2";
    end else if (!flush_n) begin
      mq.delete(); m_sv = 0; m_rd = '0; m_tag = "R11";
    end else begin
      int  occ;
      bit  wok, rok, take, load;
      occ = m_occ();
      wok = wr_en && (occ < DEPTH);
      rok = 0;
      m_tag = "";
      if (wr_en && !wok) m_tag = "R7";
      if (!m_fall) begin
        rok = rd_en && (mq.size() > 0);
        if (rd_en && !rok) m_tag = "R8";
        if (rok) m_rd = mq.pop_front();
      end else begin
        take = rd_en && m_sv;
        load = (mq.size() > 0) && (!m_sv || take);
        if (rd_en && !m_sv) m_tag = "R8";
        if (load) begin m_rd = mq.pop_front(); m_sv = 1; end
        else if (take) m_sv = 0;
        rok = take;
      end
      if (wok && rok) m_tag = "R9";
      if (wok) mq.push_back(wr_data);
    end
  end

  task automatic compare();
    int    occ;
    string td, tf;
    occ = m_occ();
    td = (m_tag != "") ? m_tag : (m_fall ? "R6" : "R4");
    tf = (m_tag != "") ? m_tag : (m_fall ? "R5" : "R4");
    chk(td, 64'(rd_data), 64'(m_rd));
    chk(tf, 64'(data_flag), 64'(m_fall ? m_sv : (mq.size() > 0)));
    chk((m_tag != "") ? m_tag : "R7", 64'(room_flag), 64'(m_cfg && occ < DEPTH));
    chk((m_cfg && int'(ae_off) != m_aeo) ? "R3" : "R10", 64'(ae_flag), 64'(occ <= m_aeo));
    chk((m_cfg && int'(af_off) != m_afo) ? "R3" : "R10", 64'(af_flag), 64'((DEPTH - occ) <= m_afo));
  endtask

  task automatic step(input bit w, input bit r, input bit fl_n);
    wr_en   = w;
    rd_en   = r;
    flush_n = fl_n;
    wr_data = {4'($urandom), 32'($urandom)};
    if (scram) begin
      mode_sel = 1'($urandom);
      ae_off   = CW'($urandom_range(0, DEPTH));
      af_off   = CW'($urandom_range(0, DEPTH));
    end
    @(negedge clk);
    compare();
  endtask

  task automatic mreset(input bit mode, input int ae, input int af);
    scram = 0;
    rst_n = 0; wr_en = 0; rd_en = 0; flush_n = 1;
    mode_sel = mode; ae_off = CW'(ae); af_off = CW'(af);
    repeat (2) @(negedge clk);
    // R1: reset values on the outputs
    chk("R1", 64'(rd_data), 64'd0);
    chk("R1", 64'(room_flag), 64'd0);
    chk("R1", 64'(data_flag), 64'd0);
    chk("R1", 64'(ae_flag), 64'd1);
    chk("R1", 64'(af_flag), 64'd0);
    rst_n = 1;
    chk("R1", 64'(room_flag), 64'd0);
    // R2: write on the capture edge is ignored
    step(1, 0, 1);
    chk("R2", 64'(data_flag), 64'd0);
    chk("R2", 64'(room_flag), 64'd1);
  endtask

  task automatic scenario(input bit mode, input int ae, input int af);
    logic [DW-1:0] w;
    mreset(mode, ae, af);
    chk("R12", 64'(ae_flag), 64'd1);
    chk("R12", 64'(data_flag), 64'd0);
    if (!mode) begin
      // R5: fall-through arrival takes two edges without a read
      step(1, 0, 1);
      w = wr_data;
      chk("R5", 64'(data_flag), 64'd0);
      step(0, 0, 1);
      chk("R5", 64'(data_flag), 64'd1);
      chk("R5", 64'(rd_data), 64'(w));
      // R6: held while no read
      step(0, 0, 1);
      chk("R6", 64'(rd_data), 64'(w));
    end
    scram = 1;
    for (int i = 0; i < DEPTH + 4; i++) step(1, 0, 1);
    chk("R7", 64'(room_flag), 64'd0);
    for (int i = 0; i < DEPTH + 4; i++) step(0, 1, 1);
    chk("R8", 64'(data_flag), 64'd0);
    for (int i = 0; i < DEPTH / 2; i++) step(1, 0, 1);
    for (int i = 0; i < 40; i++) step(1, 1, 1);
    step(0, 0, 0);
    chk("R11", 64'(data_flag), 64'd0);
    chk("R11", 64'(rd_data), 64'd0);
    for (int i = 0; i < 500; i++)
      step(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 2) != 0), ($urandom_range(0, 60) != 0));
    for (int i = 0; i < 5; i++) step(1, 0, 1);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; flush_n = 1; mode_sel = 1; wr_en = 0; rd_en = 0;
    wr_data = '0; ae_off = '0; af_off = '0;
    scenario(1, 3, 4);
    scenario(0, 5, 2);
    scenario(1, 0, DEPTH);
    scenario(0, DEPTH, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule